// File: doc/BRIEF.md
# Double-Buffered PWM Channel

This block produces one pulse-width-modulated waveform from an 8-bit counter. The counter advances on a tick input that is already prescaled elsewhere, and it is compared against an active period value and an active duty value. Software reaches the channel over a small write bus. It can load a period, load a duty, or write the counter. The live count is always visible on a read port.

Period and duty are double buffered. While the channel runs, new values wait in a buffer. They move into the active pair only at the end of the current period, on a counter write, or while the channel is stopped. A waveform cycle therefore never mixes old and new settings. A counter write clears the count and loads the buffer at once, so software can force a change without waiting. The cycle in which this happens may be irregular.

The counting sequence is held in a three-state machine. `ST_OFF` means the channel is stopped and the count holds. `ST_UP` means the count is rising. `ST_DOWN` means the count is falling, which happens in center mode only. The transitions are:

- stop: any state goes to `ST_OFF` when the synchronised enable is low.
- start: `ST_OFF` goes to `ST_UP` on the first tick after enabling.
- wrap: `ST_UP` goes to `ST_UP` with the count cleared, at the end of a left-aligned period.
- peak: `ST_UP` goes to `ST_DOWN` when a center-mode count reaches the period.
- bottom: `ST_DOWN` goes to `ST_UP` when the count returns to zero.
- restart: a counter write puts the machine in `ST_UP` with count 0, or in `ST_OFF` if the channel is stopped.

Top module: `pwm_chan`

## Requirements
- R1: After reset, the count reads 0, the buffered and active period and duty are 0, and the output sits at its inactive level (the inverse of `pol`).
- R2: The count changes only on a clock edge where the synchronised enable is high and `tick` is high. Otherwise it holds its value. A counter write is the only exception.
- R3: `en` passes through one register before it acts. A change on `en` reaches the count and the output only after the next rising clock edge.
- R4: With `pol`=1 in left-aligned mode (`center`=0), the count runs 0 … period−1 and then wraps to 0. The output is high while count < duty and low otherwise.
- R5: With `pol`=0 the waveform of R4 is inverted. The output is low while count < duty and high otherwise.
- R6: While the channel runs, writes to period (address 0) and duty (address 1) change only the buffer. The active pair takes the buffered values at the period end (the wrap, or the return to 0 in center mode).
- R7: While the channel is stopped, a period or duty write updates the buffer and the active value in the same edge.
- R8: A write to address 2 (any data) clears the count to 0 and loads the buffered period and duty into the active pair in the same edge.
- R9: With `center`=1 the count rises 0 … period and falls back to 0, so one cycle lasts 2×period ticks. The output is at its active level while count < duty.
- R10: A duty of 0 keeps the output inactive for the whole cycle. A nonzero duty that is greater than or equal to the period keeps it active for the whole cycle.
- R11: While the channel is stopped, the output is the inverse of `pol`.
- R12: A write to address 3 has no effect on the count, the period or the duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel enable, synchronised internally |
| pol | input | 1 | Active output level (1 = starts high) |
| center | input | 1 | 1 = up/down counting, 0 = left-aligned |
| tick | input | 1 | Prescaled count enable, one clock wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 period, 1 duty, 2 counter, 3 unused |
| wr_data | input | 8 | Write data |
| cnt_rd | output | 8 | Current count |
| wave | output | 1 | PWM waveform |

## Verification
Writes are issued in the middle of a running period. A design that loaded them at once would show a duty or period that changes partway through the cycle, and that cycle would not match the old waveform or the new one. A counter write is placed after buffered changes. A design that cleared the count but skipped the load would keep running the old period. The edge cases duty 0, duty equal to the period, tick held low and the cycle where enable falls are each driven. These catch output glitches at full duty, a count that creeps while gated, and an enable path that skips its register. Center mode is checked tick by tick across the peak and the bottom, and a write to address 3 must leave the running pattern untouched.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_UP   = 2'd1,
        ST_DOWN = 2'd2
    } cnt_state_t;

    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_PERIOD = 2'd0;
    localparam logic [ADDR_W-1:0] A_DUTY   = 2'd1;
    localparam logic [ADDR_W-1:0] A_COUNT  = 2'd2;
endpackage

// File: rtl/pwm_sync.sv
module pwm_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic run
);
    // enable acts only from the clock edge after it changes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run <= 1'b0;
        else        run <= en;
    end
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         load,
    input  logic         wr_per,
    input  logic         wr_duty,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] per_act,
    output logic [W-1:0] duty_act
);
    logic [W-1:0] per_buf;
    logic [W-1:0] duty_buf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_buf  <= '0;
            duty_buf <= '0;
            per_act  <= '0;
            duty_act <= '0;
        end else begin
            if (wr_per)  per_buf  <= wdata;
            if (wr_duty) duty_buf <= wdata;
            if (!run) begin
                // stopped: writes land in both copies
                per_act  <= wr_per  ? wdata : per_buf;
                duty_act <= wr_duty ? wdata : duty_buf;
            end else if (load) begin
                per_act  <= per_buf;
                duty_act <= duty_buf;
            end
        end
    end

    // R6
    hold_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load) |=> ($stable(per_act) && $stable(duty_act)));

    // R7
    direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && wr_duty) |=> (duty_act == $past(wdata)));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic         center,
    input  logic         cnt_wr,
    input  logic [W-1:0] per_act,
    output logic [W-1:0] cnt,
    output logic         load
);
    localparam int WE = W + 1;

    cnt_state_t   state_q, state_d;
    logic [W-1:0] cnt_d;
    logic         wrap;
    logic [WE-1:0] cnt_ext, cnt_inc, per_ext;

    assign cnt_ext = {1'b0, cnt};
    assign cnt_inc = cnt_ext + 1'b1;
    assign per_ext = {1'b0, per_act};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt     <= '0;
        end else begin
            state_q <= state_d;
            cnt     <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt;
        wrap    = 1'b0;
        if (cnt_wr) begin
            cnt_d   = '0;
            state_d = run ? ST_UP : ST_OFF;
        end else if (!run) begin
            state_d = ST_OFF;
        end else if (tick) begin
            unique case (state_q)
                ST_OFF, ST_UP: begin
                    if (!center) begin
                        if (cnt_inc >= per_ext) begin
                            cnt_d = '0;
                            wrap  = 1'b1;
                        end else begin
                            cnt_d = cnt + 1'b1;
                        end
                        state_d = ST_UP;
                    end else if (cnt_ext >= per_ext) begin
                        cnt_d   = '0;
                        wrap    = 1'b1;
                        state_d = ST_UP;
                    end else begin
                        cnt_d   = cnt + 1'b1;
                        state_d = (cnt_inc >= per_ext) ? ST_DOWN : ST_UP;
                    end
                end
                ST_DOWN: begin
                    if (!center || cnt <= W'(1)) begin
                        cnt_d   = '0;
                        wrap    = 1'b1;
                        state_d = ST_UP;
                    end else begin
                        cnt_d = cnt - 1'b1;
                    end
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        load = cnt_wr | wrap;
    end

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(run && tick) && !cnt_wr) |=> $stable(cnt));

    // R8
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == '0));

    // R9
    down_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DOWN) |-> (cnt != '0));
endmodule

// File: rtl/pwm_wave.sv
module pwm_wave #(
    parameter int W = 8
) (
    input  logic         run,
    input  logic         pol,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] per_act,
    input  logic [W-1:0] duty_act,
    output logic         wave
);
    always_comb begin
        if (!run)                                 wave = ~pol;
        else if (duty_act == '0)                  wave = ~pol;
        else if (duty_act >= per_act || cnt < duty_act) wave = pol;
        else                                      wave = ~pol;
    end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              pol,
    input  logic              center,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      cnt_rd,
    output logic              wave
);
    logic         run;
    logic         load;
    logic         wr_per, wr_duty, wr_cnt;
    logic [W-1:0] per_act, duty_act;

    assign wr_per  = wr_en && (wr_addr == A_PERIOD);
    assign wr_duty = wr_en && (wr_addr == A_DUTY);
    assign wr_cnt  = wr_en && (wr_addr == A_COUNT);

    pwm_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .run   (run)
    );

    pwm_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .load     (load),
        .wr_per   (wr_per),
        .wr_duty  (wr_duty),
        .wdata    (wr_data),
        .per_act  (per_act),
        .duty_act (duty_act)
    );

    pwm_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick    (tick),
        .center  (center),
        .cnt_wr  (wr_cnt),
        .per_act (per_act),
        .cnt     (cnt_rd),
        .load    (load)
    );

    pwm_wave #(.W(W)) u_wave (
        .run      (run),
        .pol      (pol),
        .cnt      (cnt_rd),
        .per_act  (per_act),
        .duty_act (duty_act),
        .wave     (wave)
    );

    // R11
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (wave == ~pol));
endmodule

// File: tb/sim_pwm_chan.sv
module sim_pwm_chan;
    logic       clk = 1'b0;
    logic       rst_n, en, pol, center, tick, wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic [7:0] cnt_rd;
    logic       wave;
    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    pwm_chan u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .pol(pol), .center(center),
        .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cnt_rd(cnt_rd), .wave(wave)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_cnt(input int k, input int per, input bit ctr);
        int c;
        if (per == 0) return 0;
        if (!ctr) return k % per;
        c = k % (2 * per);
        return (c <= per) ? c : 2 * per - c;
    endfunction

    function automatic int exp_wave(input int c, input int duty, input int per, input bit p);
        if (duty == 0) return int'(!p);
        if (duty >= per || c < duty) return int'(p);
        return int'(!p);
    endfunction

    task automatic bus_write(input logic [1:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // samples n negedges; expected follows (per0,duty0) before sample sk, (per1,duty1) after
    task automatic run_pattern(input string req, input int n, input bit do_sync, input int k0,
                               input int per0, input int duty0, input int wk,
                               input logic [1:0] wa, input int wd, input int sk,
                               input int per1, input int duty1, input bit ctr);
        int errs = 0;
        int first_k = -1, fa = 0, fe = 0;
        if (do_sync) bus_write(2'd2, 0);
        for (int k = 0; k < n; k++) begin
            int ec, ew;
            if (k > 0) @(negedge clk);
            wr_en = 1'b0;
            if (k < sk) begin
                ec = exp_cnt(k + k0, per0, ctr); ew = exp_wave(ec, duty0, per0, pol);
            end else begin
                ec = exp_cnt(k - sk, per1, ctr); ew = exp_wave(ec, duty1, per1, pol);
            end
            if (int'(cnt_rd) != ec || int'(wave) != ew) begin
                errs++;
                if (first_k < 0) begin
                    first_k = k; fa = int'(cnt_rd) * 2 + int'(wave); fe = ec * 2 + ew;
                end
            end
            if (k == wk) begin
                wr_en = 1'b1; wr_addr = wa; wr_data = 8'(wd);
            end
        end
        if (first_k >= 0)
            $display("  %s first mismatch at sample %0d: {cnt,wave} actual %0d expected %0d",
                     req, first_k, fa, fe);
        check(req, "pattern mismatches", errs, 0);
    endtask

    task automatic t_reset;
        check("R1", "count after reset", int'(cnt_rd), 0);
        check("R1", "wave after reset", int'(wave), 0);
    endtask

    task automatic t_left_pol1;
        bus_write(2'd0, 10); bus_write(2'd1, 3);
        en = 1'b1;
        run_pattern("R4", 20, 1, 0, 10, 3, -1, 2'd0, 0, 20, 10, 3, 1'b0);
    endtask

    task automatic t_left_pol0;
        pol = 1'b0;
        bus_write(2'd0, 8); bus_write(2'd1, 5);
        run_pattern("R5", 16, 1, 0, 8, 5, -1, 2'd0, 0, 16, 8, 5, 1'b0);
        pol = 1'b1;
    endtask

    task automatic t_extremes;
        bus_write(2'd0, 5); bus_write(2'd1, 0);
        run_pattern("R10", 10, 1, 0, 5, 0, -1, 2'd0, 0, 10, 5, 0, 1'b0);
        bus_write(2'd1, 5);
        run_pattern("R10", 10, 1, 0, 5, 5, -1, 2'd0, 0, 10, 5, 5, 1'b0);
        center = 1'b1;
        bus_write(2'd0, 4); bus_write(2'd1, 4);
        run_pattern("R10", 16, 1, 0, 4, 4, -1, 2'd0, 0, 16, 4, 4, 1'b1);
        center = 1'b0;
    endtask

    task automatic t_center;
        center = 1'b1;
        bus_write(2'd0, 6); bus_write(2'd1, 2);
        run_pattern("R9", 24, 1, 0, 6, 2, -1, 2'd0, 0, 24, 6, 2, 1'b1);
        center = 1'b0;
    endtask

    task automatic t_buffered;
        bus_write(2'd0, 10); bus_write(2'd1, 3);
        run_pattern("R6", 20, 1, 0, 10, 3, 1, 2'd1, 7, 10, 10, 7, 1'b0);
        bus_write(2'd1, 3);
        run_pattern("R6", 20, 1, 0, 10, 3, 1, 2'd0, 6, 10, 6, 3, 1'b0);
    endtask

    task automatic t_force;
        bus_write(2'd0, 10); bus_write(2'd1, 3);
        bus_write(2'd2, 0);
        bus_write(2'd0, 6); bus_write(2'd1, 2);
        check("R8", "count before forced write", int'(cnt_rd), 4);
        run_pattern("R8", 16, 0, 4, 10, 3, 1, 2'd2, 0, 2, 6, 2, 1'b0);
    endtask

    task automatic t_unused_addr;
        bus_write(2'd0, 10); bus_write(2'd1, 3);
        run_pattern("R12", 20, 1, 0, 10, 3, 2, 2'd3, 0, 20, 10, 3, 1'b0);
    endtask

    task automatic t_gating;
        bus_write(2'd0, 10); bus_write(2'd1, 3);
        bus_write(2'd2, 0);
        tick = 1'b0;
        repeat (5) @(negedge clk);
        check("R2", "count with tick low", int'(cnt_rd), 0);
        tick = 1'b1;
        repeat (3) @(negedge clk);
        check("R2", "count after 3 ticks", int'(cnt_rd), 3);
        en = 1'b0;
        repeat (5) @(negedge clk);
        check("R2", "count held while stopped", int'(cnt_rd), 4);
        check("R11", "wave while stopped", int'(wave), 0);
    endtask

    task automatic t_stopped_write;
        bus_write(2'd2, 0);
        bus_write(2'd0, 8); bus_write(2'd1, 5);
        check("R11", "wave stopped after writes", int'(wave), 0);
        en = 1'b1;
        #5;
        check("R3", "wave before enable edge", int'(wave), 0);
        @(negedge clk);
        run_pattern("R7", 16, 0, 0, 8, 5, -1, 2'd0, 0, 16, 8, 5, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; en = 1'b0; pol = 1'b1; center = 1'b0; tick = 1'b1;
        wr_en = 1'b0; wr_addr = 2'd0; wr_data = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_left_pol1();
        t_left_pol0();
        t_extremes();
        t_center();
        t_buffered();
        t_force();
        t_unused_addr();
        t_gating();
        t_stopped_write();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule